// File: doc/BRIEF.md
# Watchdog Timer with System Reset Pulse

This block guards a system against a hang caused by a bad clock setting. Software loads an 8-bit time value, in units of one timebase tick (250 ms in the target system), and starts the timer. While running, the counter steps down once per tick. A host that is alive keeps rewriting the time value, and each such write restarts the countdown. If the count runs out, the block does three things. It latches a sticky timeout flag. It emits a one-cycle timeout pulse, which the frequency controller uses to fall back to its safe setting and to drop any divider programming. It pulls the active-low open-drain system reset low for a fixed number of ticks.

The tick is derived from the block clock by a prescaler of `TICK_CYCLES` cycles. The timer's enable state comes up from a board strap that is sampled on the rising edge of the power-good input. Software can override it at any time through the enable write. The host reads back the live count, whether the timer is running, and the timeout flag.

Top module: `wdt_pulse_reset`

## Requirements
- R1: After reset the timer is stopped, the count reads `DEFAULT_TIME` (8), the timeout flag and the timeout pulse are 0, and the reset pin is released (1).
- R2: On the rising edge of `pwr_good`, the timer starts from the stored time value if `strap_en` is 1. If `strap_en` is 0, the timer stays stopped.
- R3: An enable write with `ctl_en`=1 starts the timer. It loads the count from the stored time value, restarts the prescaler, clears the timeout flag and makes `wd_running` read 1.
- R4: While running, `wd_count` decreases by one exactly every `TICK_CYCLES` clock cycles, counted from the start edge.
- R5: A time value N ≥ 1 expires on the N-th tick after start. In that cycle the timeout flag becomes 1, `wd_running` becomes 0, `wd_count` becomes 0 and `timeout_pulse` is 1 for exactly one cycle.
- R6: A time value of 0 expires on the first tick after start.
- R7: `sys_rst_od_n` is 0 for exactly `RST_TICKS*TICK_CYCLES` cycles, starting with the cycle in which the timeout pulse is high.
- R8: A time write while running reloads the count and the prescaler, so it acts as a keep-alive. A time write while stopped stores the value, shows it on `wd_count` and starts nothing.
- R9: An enable write with `ctl_en`=0 stops the timer. The count holds and no timeout occurs.
- R10: The timeout flag cannot be cleared by a stop write or a time write. It clears only when the timer is started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, source of the tick prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; its rising edge samples the strap |
| strap_en | input | 1 | Enable strap value |
| ctl_wr | input | 1 | Enable write strobe |
| ctl_en | input | 1 | Enable value written with `ctl_wr` |
| time_wr | input | 1 | Time value write strobe |
| time_val | input | TIME_W | Time value in ticks written with `time_wr` |
| sys_rst_od_n | output | 1 | Open-drain reset control: 0 pulls low, 1 releases |
| timeout_pulse | output | 1 | One-cycle expiry strobe toward the frequency controller |
| wd_running | output | 1 | 1 while the countdown is active |
| wd_timed_out | output | 1 | Sticky timeout flag |
| wd_count | output | TIME_W | Live down-count |

## Verification
The bench builds the block with `TICK_CYCLES`=4 and `RST_TICKS`=2. A tick therefore lasts four cycles and the reset pulse lasts eight. At these values a full expiry and the whole reset pulse fit within a few dozen cycles, so each one can be checked at its exact edge rather than inside a window. The short tick also makes it easy to test a keep-alive write that lands between ticks, a zero time value and the power-good strap path.

// File: rtl/wdt_pulse_reset.sv
module wdt_pulse_reset #(
  parameter int TIME_W       = 8,
  parameter int DEFAULT_TIME = 8,
  parameter int TICK_CYCLES  = 250000,
  parameter int RST_TICKS    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              strap_en,
  input  logic              ctl_wr,
  input  logic              ctl_en,
  input  logic              time_wr,
  input  logic [TIME_W-1:0] time_val,
  output logic              sys_rst_od_n,
  output logic              timeout_pulse,
  output logic              wd_running,
  output logic              wd_timed_out,
  output logic [TIME_W-1:0] wd_count
);
  localparam int PRE_W      = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int RST_CYCLES = TICK_CYCLES * RST_TICKS;
  localparam int RST_W      = $clog2(RST_CYCLES + 1);

  logic              pg_q;
  logic [TIME_W-1:0] time_reg;
  logic [PRE_W-1:0]  pre;
  logic [RST_W-1:0]  rst_cnt;

  wire pg_rise   = pwr_good & ~pg_q;
  wire en_wr     = ctl_wr | pg_rise;
  wire en_val    = ctl_wr ? ctl_en : strap_en;
  wire start_req = en_wr & en_val;
  wire stop_req  = en_wr & ~en_val;
  wire tick      = wd_running & (pre == PRE_W'(TICK_CYCLES - 1));
  wire expire    = tick & ~en_wr & ~time_wr & (wd_count <= TIME_W'(1));

  assign sys_rst_od_n = (rst_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q          <= 1'b0;
      time_reg      <= TIME_W'(DEFAULT_TIME);
      wd_count      <= TIME_W'(DEFAULT_TIME);
      pre           <= '0;
      wd_running    <= 1'b0;
      wd_timed_out  <= 1'b0;
      timeout_pulse <= 1'b0;
      rst_cnt       <= '0;
    end else begin
      pg_q          <= pwr_good;
      timeout_pulse <= expire;

      if (time_wr)
        time_reg <= time_val;

      if (start_req)
        wd_count <= time_wr ? time_val : time_reg;
      else if (time_wr)
        wd_count <= time_val;
      else if (expire)
        wd_count <= '0;
      else if (tick && !stop_req)
        wd_count <= wd_count - 1'b1;

      if (start_req || time_wr || tick || !wd_running)
        pre <= '0;
      else
        pre <= pre + 1'b1;

      if (start_req)
        wd_running <= 1'b1;
      else if (stop_req || expire)
        wd_running <= 1'b0;

      if (start_req)
        wd_timed_out <= 1'b0;
      else if (expire)
        wd_timed_out <= 1'b1;

      if (expire)
        rst_cnt <= RST_W'(RST_CYCLES);
      else if (rst_cnt != '0)
        rst_cnt <= rst_cnt - 1'b1;
    end
  end

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_running && !en_wr && !time_wr) |=>
      (wd_count == $past(wd_count) || wd_count == $past(wd_count) - 1'b1));

  // R5
  expiry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> (wd_timed_out && !wd_running && wd_count == '0));

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  // R7
  reset_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> !sys_rst_od_n);

  // R9
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_running && !start_req && !time_wr) |=> $stable(wd_count));

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_timed_out && !start_req) |=> wd_timed_out);
endmodule

// File: tb/wdt_pulse_reset_bench.sv
module wdt_pulse_reset_bench;
  localparam int TICK = 4;
  localparam int RSTT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b0, strap_en = 1'b0;
  logic       ctl_wr = 1'b0, ctl_en = 1'b0, time_wr = 1'b0;
  logic [7:0] time_val = '0;
  logic       sys_rst_od_n, timeout_pulse, wd_running, wd_timed_out;
  logic [7:0] wd_count;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_pulse_reset #(.TIME_W(8), .DEFAULT_TIME(8), .TICK_CYCLES(TICK), .RST_TICKS(RSTT)) u_wdt_pulse_reset (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_en(strap_en),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .time_wr(time_wr), .time_val(time_val),
    .sys_rst_od_n(sys_rst_od_n), .timeout_pulse(timeout_pulse),
    .wd_running(wd_running), .wd_timed_out(wd_timed_out), .wd_count(wd_count));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic v);
    ctl_wr = 1'b1; ctl_en = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_time(input logic [7:0] v);
    time_wr = 1'b1; time_val = v;
    @(negedge clk);
    time_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "running", wd_running, 0);
    chk("R1", "count", wd_count, 8);
    chk("R1", "flag", wd_timed_out, 0);
    chk("R1", "pulse", timeout_pulse, 0);
    chk("R1", "rst pin", sys_rst_od_n, 1);
  endtask

  task automatic t_strap;
    strap_en = 1'b0; pwr_good = 1'b1;
    @(negedge clk);
    wait_n(2);
    chk("R2", "strap 0 running", wd_running, 0);
    pwr_good = 1'b0; wait_n(1);
    strap_en = 1'b1; pwr_good = 1'b1;
    @(negedge clk);
    chk("R2", "strap 1 running", wd_running, 1);
    chk("R2", "strap 1 count", wd_count, 8);
    wait_n(3);
    chk("R4", "count before tick", wd_count, 8);
    wait_n(1);
    chk("R4", "count after tick 1", wd_count, 7);
    wait_n(4);
    chk("R4", "count after tick 2", wd_count, 6);
  endtask

  task automatic t_stop;
    wr_ctl(1'b0);
    chk("R9", "running after stop", wd_running, 0);
    wait_n(60);
    chk("R9", "count held", wd_count, 6);
    chk("R9", "no timeout", wd_timed_out, 0);
    chk("R9", "rst released", sys_rst_od_n, 1);
  endtask

  task automatic t_expire;
    wr_time(8'd3);
    chk("R8", "stopped write count", wd_count, 3);
    chk("R8", "stopped write not running", wd_running, 0);
    wait_n(8);
    chk("R8", "still stopped", wd_count, 3);
    wr_ctl(1'b1);
    chk("R3", "running", wd_running, 1);
    chk("R3", "count loaded", wd_count, 3);
    wait_n(3*TICK - 1);
    chk("R5", "flag before expiry", wd_timed_out, 0);
    chk("R5", "count before expiry", wd_count, 1);
    wait_n(1);
    chk("R5", "flag", wd_timed_out, 1);
    chk("R5", "pulse", timeout_pulse, 1);
    chk("R5", "running", wd_running, 0);
    chk("R5", "count", wd_count, 0);
    chk("R7", "rst low first", sys_rst_od_n, 0);
    wait_n(1);
    chk("R5", "pulse one cycle", timeout_pulse, 0);
    wait_n(RSTT*TICK - 2);
    chk("R7", "rst low last", sys_rst_od_n, 0);
    wait_n(1);
    chk("R7", "rst released", sys_rst_od_n, 1);
  endtask

  task automatic t_sticky;
    wr_ctl(1'b0);
    chk("R10", "flag after stop write", wd_timed_out, 1);
    wr_time(8'd5);
    chk("R10", "flag after time write", wd_timed_out, 1);
    wr_ctl(1'b1);
    chk("R10", "flag cleared by start", wd_timed_out, 0);
    chk("R3", "count from stored value", wd_count, 5);
    wr_ctl(1'b0);
  endtask

  task automatic t_zero;
    wr_time(8'd0);
    wr_ctl(1'b1);
    wait_n(TICK - 1);
    chk("R6", "not yet", wd_timed_out, 0);
    chk("R6", "running", wd_running, 1);
    wait_n(1);
    chk("R6", "expired on first tick", wd_timed_out, 1);
    chk("R6", "pulse", timeout_pulse, 1);
    wait_n(RSTT*TICK + 2);
  endtask

  task automatic t_keepalive;
    wr_time(8'd2);
    wr_ctl(1'b1);
    wait_n(6);
    chk("R4", "count mid", wd_count, 1);
    wr_time(8'd2);
    chk("R8", "reloaded count", wd_count, 2);
    wait_n(7);
    chk("R8", "no early expiry", wd_timed_out, 0);
    chk("R8", "count one left", wd_count, 1);
    wait_n(1);
    chk("R8", "expiry after reload", wd_timed_out, 1);
    wait_n(RSTT*TICK + 2);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog: actual hung expected done");
          $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
          $finish;
        end
      end
    join_none
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_strap();
    t_stop();
    t_expire();
    t_sticky();
    t_zero();
    t_keepalive();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule